// File: doc/BRIEF.md
# Configuration Register Unlock and Access Detector

This block sits in the access path of a pseudo-static memory that behaves like an asynchronous SRAM. Each access arrives as one record per clock, with a valid strobe, a read/write flag, the address, the write data and the level of a register-enable input. The block holds the two configuration registers, a refresh register and a bus register. It decides, for every access, whether the access belongs to the memory array or must be taken by the registers instead.

There are two ways to reach the registers. With the register-enable input low, software can use a fixed sequence of four accesses, all to the highest device address. The first two are reads. The third is a write whose data selects the register. The fourth is either a write that loads the register or a read that returns it. With the register-enable input high, every access goes to the registers. A write loads the value carried on the low address lines, and one address bit picks the register. Responses come out one clock after the access: a divert flag, read data, and a one-cycle write strobe for each register.

Top module: `pcfg_access_ctrl`

## Requirements
- R1: After reset the refresh register holds 16'h0010, the bus register holds 16'h9D1F, and no response, divert or strobe is active.
- R2: The software sequence is a read of the top address (all address bits one), a second read of it, and a write to it with data 16'h0000 (refresh register) or 16'h0001 (bus register). A fourth access, a write to the top address, loads its 16 data bits into the selected register. The matching strobe (wstb_rcr or wstb_bcr) pulses in the response cycle and the new value is visible on the register output in that same cycle.
- R3: If the fourth access of the sequence is a read of the top address, rsp_rdata returns the selected register's value with rsp_divert high.
- R4: The select write and the fourth access of the sequence are diverted. The two opening reads are not diverted, so the data stored at the top address is never changed by the sequence.
- R5: A third consecutive read of the top address cancels the sequence. While cancelled, no access to the top address can start a sequence. Only a read of another address returns the detector to idle.
- R6: An access to any other address in the middle of the sequence returns the detector to idle and goes to the array. So does a select write whose data is neither 16'h0000 nor 16'h0001, or any other access that does not continue the sequence.
- R7: With acc_cre high, every access is diverted. Address bit 19 chooses the register (1 = bus, 0 = refresh). A write loads acc_addr[15:0], and a read returns the chosen register. Such an access also returns the sequence detector to idle.
- R8: A software-sequence load of the refresh register leaves bit 4 (the deep power-down control) unchanged. A load through acc_cre writes all 16 bits.
- R9: Every valid access gives exactly one rsp_valid, one clock later. A cycle without an access gives none. An access that is not diverted returns rsp_rdata of zero.
- R10: At most one write strobe is high in any cycle, and a strobe is only ever high together with rsp_divert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access record is present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_cre | input | 1 | Register-enable level of the access |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 16 | Write data of the access |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_divert | output | 1 | That access was taken by the registers, not the array |
| rsp_rdata | output | 16 | Register read data for a diverted read, else zero |
| wstb_rcr | output | 1 | Refresh register was written |
| wstb_bcr | output | 1 | Bus register was written |
| rcr_value | output | 16 | Current refresh register contents |
| bcr_value | output | 16 | Current bus register contents |

## Verification
A detector stuck in the wrong sequence state shows up at the very next access to the top address. The divert flag of that response differs from the expected one one clock after the access, for example when a select write goes to the array or a read-back is missing. A wrong register index or a lost power-down guard shows on the register outputs in the same response cycle as the write strobe. The cancel state is visible only through the absence of diversion on later top-address accesses, so the bench drives full sequences while cancelled and again after leaving that state.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_REGS = 2;
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int IDX_RCR  = 0;
  localparam int IDX_BCR  = 1;
  localparam int PD_BIT   = 4;

  localparam logic [REG_W-1:0] RCR_RESET = 16'h0010;
  localparam logic [REG_W-1:0] BCR_RESET = 16'h9D1F;
  localparam logic [REG_W-1:0] CODE_RCR  = 16'h0000;
  localparam logic [REG_W-1:0] CODE_BCR  = 16'h0001;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ONE   = 3'd1,
    SQ_TWO   = 3'd2,
    SQ_SELR  = 3'd3,
    SQ_SELB  = 3'd4,
    SQ_HOLD  = 3'd5
  } seq_state_t;

  function automatic logic [REG_W-1:0] reset_of(input int idx);
    return (idx == IDX_BCR) ? BCR_RESET : RCR_RESET;
  endfunction
endpackage

// File: rtl/pcfg_seq_track.sv
module pcfg_seq_track
  import pcfg_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              write,
  input  logic              cre,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic              hit_divert,
  output logic              hit_load,
  output logic              hit_read,
  output logic [SEL_W-1:0]  hit_sel
);
  seq_state_t state_q, state_d;
  logic       at_top;

  assign at_top = &addr;

  always_comb begin
    state_d    = state_q;
    hit_divert = 1'b0;
    hit_load   = 1'b0;
    hit_read   = 1'b0;
    hit_sel    = SEL_W'(IDX_RCR);
    if (valid) begin
      if (cre) begin
        state_d = SQ_IDLE;
      end else begin
        unique case (state_q)
          SQ_IDLE: state_d = (at_top && !write) ? SQ_ONE : SQ_IDLE;
          SQ_ONE:  state_d = (at_top && !write) ? SQ_TWO : SQ_IDLE;
          SQ_TWO: begin
            if (at_top && !write) begin
              state_d = SQ_HOLD;
            end else if (at_top && write && wdata == CODE_RCR) begin
              state_d    = SQ_SELR;
              hit_divert = 1'b1;
            end else if (at_top && write && wdata == CODE_BCR) begin
              state_d    = SQ_SELB;
              hit_divert = 1'b1;
            end else begin
              state_d = SQ_IDLE;
            end
          end
          SQ_SELR, SQ_SELB: begin
            state_d = SQ_IDLE;
            if (at_top) begin
              hit_divert = 1'b1;
              hit_load   = write;
              hit_read   = !write;
              hit_sel    = (state_q == SQ_SELB) ? SEL_W'(IDX_BCR) : SEL_W'(IDX_RCR);
            end
          end
          SQ_HOLD: state_d = (!at_top && !write) ? SQ_IDLE : SQ_HOLD;
          default: state_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pcfg_reg_bank.sv
module pcfg_reg_bank
  import pcfg_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic [SEL_W-1:0]                sel,
  input  logic [REG_W-1:0]                wdata,
  input  logic                            guard_pd,
  output logic [NUM_REGS-1:0][REG_W-1:0]  values
);
  localparam logic [REG_W-1:0] PD_MASK = REG_W'(1) << PD_BIT;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] next_val;
    if (g == IDX_RCR) begin : g_guarded
      assign next_val = guard_pd ? ((wdata & ~PD_MASK) | (values[g] & PD_MASK)) : wdata;
    end else begin : g_plain
      assign next_val = wdata;
    end
    always_ff @(posedge clk) begin
      if (rst)                                values[g] <= reset_of(g);
      else if (load && sel == SEL_W'(g))      values[g] <= next_val;
    end
  end
endmodule

// File: rtl/pcfg_access_ctrl.sv
module pcfg_access_ctrl
  import pcfg_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int SEL_BIT = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_cre,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  output logic              rsp_valid,
  output logic              rsp_divert,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              wstb_rcr,
  output logic              wstb_bcr,
  output logic [REG_W-1:0]  rcr_value,
  output logic [REG_W-1:0]  bcr_value
);
  logic                           sq_div, sq_load, sq_read;
  logic [SEL_W-1:0]               sq_sel;
  logic                           cre_hit;
  logic                           eff_div, eff_load, eff_read;
  logic [SEL_W-1:0]               eff_sel;
  logic [REG_W-1:0]               eff_data;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;

  pcfg_seq_track #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .valid(acc_valid), .write(acc_write), .cre(acc_cre),
    .addr(acc_addr), .wdata(acc_wdata), .hit_divert(sq_div), .hit_load(sq_load),
    .hit_read(sq_read), .hit_sel(sq_sel)
  );

  assign cre_hit  = acc_valid && acc_cre;
  assign eff_div  = cre_hit || sq_div;
  assign eff_load = cre_hit ? acc_write : sq_load;
  assign eff_read = cre_hit ? !acc_write : sq_read;
  assign eff_sel  = cre_hit ? (acc_addr[SEL_BIT] ? SEL_W'(IDX_BCR) : SEL_W'(IDX_RCR)) : sq_sel;
  assign eff_data = cre_hit ? acc_addr[REG_W-1:0] : acc_wdata;

  pcfg_reg_bank u_bank (
    .clk(clk), .rst(rst), .load(eff_load), .sel(eff_sel), .wdata(eff_data),
    .guard_pd(!cre_hit), .values(regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_divert <= 1'b0;
      rsp_rdata  <= '0;
      wstb_rcr   <= 1'b0;
      wstb_bcr   <= 1'b0;
    end else begin
      rsp_valid  <= acc_valid;
      rsp_divert <= eff_div;
      rsp_rdata  <= eff_read ? regs[eff_sel] : '0;
      wstb_rcr   <= eff_load && (eff_sel == SEL_W'(IDX_RCR));
      wstb_bcr   <= eff_load && (eff_sel == SEL_W'(IDX_BCR));
    end
  end

  assign rcr_value = regs[IDX_RCR];
  assign bcr_value = regs[IDX_BCR];
endmodule

// File: rtl/pcfg_access_ctrl_chk.sv
module pcfg_access_ctrl_chk
  import pcfg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_cre,
  input logic             rsp_valid,
  input logic             rsp_divert,
  input logic [REG_W-1:0] rsp_rdata,
  input logic             wstb_rcr,
  input logic             wstb_bcr,
  input logic [REG_W-1:0] rcr_value,
  input logic [REG_W-1:0] bcr_value
);
  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wstb_rcr, wstb_bcr}));

  p_strobe_diverted_r10: assert property (@(posedge clk) disable iff (rst)
    (wstb_rcr || wstb_bcr) |-> (rsp_divert && rsp_valid));

  p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !rsp_divert |-> (rsp_rdata == '0));

  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  p_no_rsp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid);

  p_rcr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wstb_rcr |-> $stable(rcr_value));

  p_bcr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wstb_bcr |-> $stable(bcr_value));

  p_pd_guard_r8: assert property (@(posedge clk) disable iff (rst)
    (wstb_rcr && !$past(acc_cre)) |-> (rcr_value[PD_BIT] == $past(rcr_value[PD_BIT])));
endmodule

bind pcfg_access_ctrl pcfg_access_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_cre(acc_cre),
  .rsp_valid(rsp_valid), .rsp_divert(rsp_divert), .rsp_rdata(rsp_rdata),
  .wstb_rcr(wstb_rcr), .wstb_bcr(wstb_bcr), .rcr_value(rcr_value), .bcr_value(bcr_value)
);

// File: tb/pcfg_access_ctrl_tb.sv
module pcfg_access_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  localparam logic [AW-1:0] OTHER = 22'h001234;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_cre = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic rsp_valid, rsp_divert, wstb_rcr, wstb_bcr;
  logic [15:0] rsp_rdata, rcr_value, bcr_value;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // reference model state
  int   m_state = 0; // 0 idle,1 one read,2 two reads,3 sel refresh,4 sel bus,5 cancelled
  logic [15:0] m_rcr = 16'h0010, m_bcr = 16'h9D1F;
  logic e_valid = 0, e_div = 0, e_wr = 0, e_wb = 0;
  logic [15:0] e_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcfg_access_ctrl #(.ADDR_W(AW), .SEL_BIT(19)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write), .acc_cre(acc_cre),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_divert(rsp_divert),
    .rsp_rdata(rsp_rdata), .wstb_rcr(wstb_rcr), .wstb_bcr(wstb_bcr),
    .rcr_value(rcr_value), .bcr_value(bcr_value)
  );

  task automatic model(input logic w, input logic [AW-1:0] a, input logic [15:0] d, input logic c);
    logic top;
    top = (a == TOP);
    e_valid = 1; e_div = 0; e_wr = 0; e_wb = 0; e_rdata = 0;
    if (c) begin
      e_div = 1;
      m_state = 0;
      if (w) begin
        if (a[19]) begin m_bcr = a[15:0]; e_wb = 1; end
        else begin m_rcr = a[15:0]; e_wr = 1; end
      end else begin
        e_rdata = a[19] ? m_bcr : m_rcr;
      end
    end else if (m_state == 5) begin
      if (!top && !w) m_state = 0;
    end else if (m_state == 3 || m_state == 4) begin
      if (top) begin
        e_div = 1;
        if (w) begin
          if (m_state == 4) begin m_bcr = d; e_wb = 1; end
          else begin m_rcr = {d[15:5], m_rcr[4], d[3:0]}; e_wr = 1; end
        end else begin
          e_rdata = (m_state == 4) ? m_bcr : m_rcr;
        end
      end
      m_state = 0;
    end else if (m_state == 2) begin
      if (top && !w) m_state = 5;
      else if (top && w && d == 16'h0000) begin m_state = 3; e_div = 1; end
      else if (top && w && d == 16'h0001) begin m_state = 4; e_div = 1; end
      else m_state = 0;
    end else begin
      m_state = (top && !w) ? m_state + 1 : 0;
    end
  endtask

  task automatic check();
    n_cmp++;
    if (rsp_valid !== e_valid || rsp_divert !== e_div || rsp_rdata !== e_rdata ||
        wstb_rcr !== e_wr || wstb_bcr !== e_wb || rcr_value !== m_rcr || bcr_value !== m_bcr) begin
      n_bad++;
      $display("FAIL %s: got v=%b d=%b rd=%h sr=%b sb=%b rcr=%h bcr=%h exp v=%b d=%b rd=%h sr=%b sb=%b rcr=%h bcr=%h",
               cur_req, rsp_valid, rsp_divert, rsp_rdata, wstb_rcr, wstb_bcr, rcr_value, bcr_value,
               e_valid, e_div, e_rdata, e_wr, e_wb, m_rcr, m_bcr);
    end
  endtask

  task automatic set_idle();
    e_valid = 0; e_div = 0; e_wr = 0; e_wb = 0; e_rdata = 0;
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [15:0] d, input logic c);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_wdata = d; acc_cre = c;
    model(w, a, d, c);
    @(negedge clk);
    check();
    acc_valid = 0; acc_write = 0; acc_cre = 0;
    set_idle();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      set_idle();
      @(negedge clk);
      check();
    end
  endtask

  task automatic rd(input logic [AW-1:0] a); acc(1'b0, a, 16'h0, 1'b0); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d); acc(1'b1, a, d, 1'b0); endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    cur_req = "R1"; idle(3);

    // R2: load bus register through the sequence
    cur_req = "R2"; rd(TOP); rd(TOP); wr(TOP, 16'h0001); wr(TOP, 16'h1234); idle(1);
    // R3: read it back
    cur_req = "R3"; rd(TOP); rd(TOP); wr(TOP, 16'h0001); rd(TOP); idle(2);
    // R8: software load of refresh register keeps bit 4
    cur_req = "R8"; rd(TOP); rd(TOP); wr(TOP, 16'h0000); wr(TOP, 16'h0085);
    cur_req = "R3"; rd(TOP); rd(TOP); wr(TOP, 16'h0000); rd(TOP);
    // R4: back-to-back sequences, with gaps; opening reads stay on the array
    cur_req = "R4"; rd(TOP); idle(2); rd(TOP); idle(1); wr(TOP, 16'h0001); idle(3); wr(TOP, 16'hA5A5);

    // R5: cancel by a third read, then attempts while cancelled
    cur_req = "R5"; rd(TOP); rd(TOP); rd(TOP); wr(TOP, 16'h0000); wr(TOP, 16'h5555);
    rd(TOP); rd(TOP); wr(TOP, 16'h0001); wr(TOP, 16'h7777);
    wr(OTHER, 16'h1111); rd(TOP); rd(TOP); wr(TOP, 16'h0000);
    rd(OTHER); rd(TOP); rd(TOP); wr(TOP, 16'h0000); wr(TOP, 16'h0013);

    // R6: interruptions and bad select codes
    cur_req = "R6"; rd(TOP); rd(OTHER); wr(TOP, 16'h0000); wr(TOP, 16'h0007);
    rd(TOP); rd(TOP); wr(TOP, 16'h0002); wr(TOP, 16'h0009);
    rd(TOP); rd(TOP); wr(OTHER, 16'h0001); wr(TOP, 16'h0009);
    rd(TOP); rd(TOP); wr(TOP, 16'h0001); rd(OTHER); rd(TOP);
    rd(TOP); wr(TOP, 16'h0000); wr(TOP, 16'h0000);

    // R7: register-enable path
    cur_req = "R7"; acc(1'b1, 22'h08BEEF, 16'h0, 1'b1); acc(1'b0, 22'h080000, 16'h0, 1'b1);
    acc(1'b0, 22'h000000, 16'h0, 1'b1);
    // R8: register-enable path may clear bit 4
    cur_req = "R8"; acc(1'b1, 22'h3F0000, 16'h0, 1'b1); acc(1'b1, 22'h000102, 16'h0, 1'b1);
    // R7: register-enable access in mid-sequence resets detector
    cur_req = "R7"; rd(TOP); rd(TOP); acc(1'b0, TOP, 16'h0, 1'b1); wr(TOP, 16'h0000); wr(TOP, 16'h00FF);
    rd(TOP); rd(TOP); wr(TOP, 16'h0001); acc(1'b1, 22'h000777, 16'h0, 1'b1); wr(TOP, 16'h4321);

    // R9/R10: plain array traffic and gaps
    cur_req = "R9"; wr(OTHER, 16'hFFFF); rd(OTHER); idle(2); rd(22'h3FFFFE); wr(TOP, 16'h0001);
    cur_req = "R10"; rd(TOP); rd(TOP); wr(TOP, 16'h0000); wr(TOP, 16'hFFFF); idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule